// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the control and status logic in front of a successive-approximation converter. Software programs it through a small word-addressed register port: a control word (flags, interrupt enable, trigger source, operating mode, channel bank), a range word (first and last channel of the scan) and a read-only result word. Conversions can be started by a software start bit, by an external trigger pin or by a timer pulse, depending on the selected trigger source.

The sequencer drives a conversion engine with a one-cycle start pulse and a 6-bit channel number, and waits for a done pulse carrying the converted value. It steps through the channel range, wrapping past the top channel back to channel 0 when the first channel is above the last one. It supports two single-pass modes, a repeating mode and a step-per-trigger mode. It keeps the busy, interrupt and pause flags, and raises an interrupt request.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset all three register words read 0 (address 0 control, 1 range, 2 result), `irq_o` is 0 and no conversion start is issued.
- R2: In mode 01 (control bits 9:8), a start converts each channel from the first channel (range bits 4:0) up to the last channel (range bits 12:8) once, in ascending order, then busy (control bit 0) reads 0.
- R3: When the first channel is above the last, the scan runs from the first channel up to 31 and continues from 0 to the last; when the two are equal only that channel is converted.
- R4: With the bank bit (control bit 10) set, every channel number presented on `conv_chan_o` is the range channel plus 32.
- R5: Trigger source field (control bits 5:4): 00 software only, 01 adds the external pin, 10 adds the timer, 11 adds both. Pulses on a disabled source start nothing. Software start is control bit 6, which always reads 0.
- R6: In mode 00 a trigger during a conversion restarts the scan at the first channel; in modes 01, 10 and 11 such a trigger is ignored.
- R7: Mode 10 repeats the scan without end. Mode 11 converts one channel per activation, stays busy between activations, and resumes at the next channel, returning to the first channel after the last.
- R8: Writing 0 to the busy bit stops the sequence; a result that completes later is discarded. Writing 1 to it has no effect.
- R9: Every completed conversion overwrites the result word (bits 9:0) and sets the interrupt flag (control bit 1). Writing 0 to that flag clears it, writing 1 has no effect. `irq_o` is the flag ANDed with interrupt enable (control bit 2).
- R10: In modes 10 and 11, a conversion that finishes while the interrupt flag is still set sets the pause flag (control bit 3) and is held back: no new result is written and no new conversion starts until the flag is cleared. Writing 0 to the pause bit clears it.
- R11: A read with `rmw_i` high returns 1 in the busy, interrupt and pause bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 range |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address: 0 control, 1 range, 2 result |
| rmw_i | input | 1 | Current read is the read half of a read-modify-write |
| rd_data_o | output | 16 | Read data (combinational) |
| ext_trig_i | input | 1 | External trigger pin pulse |
| tmr_trig_i | input | 1 | Timer trigger pulse |
| conv_start_o | output | 1 | One-cycle start to the conversion engine |
| conv_chan_o | output | 6 | Channel to convert, bank bit on top |
| conv_done_i | input | 1 | Conversion finished pulse |
| conv_data_i | input | 10 | Converted value, valid with done |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the sequencer with its default 5-bit channel field and 10-bit result, so the full channel space and the step from 31 back to 0 are reached in short scans, and the bank bit places channels in the upper half of the 6-bit channel output. A model engine with a fixed four-cycle latency answers each start; this keeps a conversion in flight long enough to land a retrigger, a forced stop or an interrupt-flag clear inside it, and to let a held result wait behind an uncleared flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MD_SINGLE_RT = 2'b00,
    MD_SINGLE    = 2'b01,
    MD_CONT      = 2'b10,
    MD_STEP      = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_HOLD,
    ST_PARK
  } state_e;

  // control word bit positions
  localparam int B_BUSY  = 0;
  localparam int B_INT   = 1;
  localparam int B_IE    = 2;
  localparam int B_PAUSE = 3;
  localparam int B_SRC   = 4;
  localparam int B_START = 6;
  localparam int B_MODE  = 8;
  localparam int B_BANK  = 10;
  // range word field positions
  localparam int B_FIRST = 0;
  localparam int B_LAST  = 8;
  // addresses
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_RANGE = 2'd1;
  localparam logic [1:0] A_RES   = 2'd2;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel (
  input  logic       sw_i,
  input  logic       ext_i,
  input  logic       tmr_i,
  input  logic [1:0] src_i,
  output logic       trig_o
);
  assign trig_o = sw_i | (ext_i & src_i[0]) | (tmr_i & src_i[1]);
endmodule

// File: rtl/adc_chan_ptr.sv
module adc_chan_ptr #(
  parameter int CH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic [CH_W-1:0] first_i,
  input  logic [CH_W-1:0] last_i,
  output logic [CH_W-1:0] ch_o,
  output logic            at_last_o
);
  logic [CH_W-1:0] ch_q;

  assign ch_o      = ch_q;
  assign at_last_o = (ch_q == last_i);

  // natural overflow of ch_q gives the top-to-zero wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ch_q <= '0;
    else if (load_i)    ch_q <= first_i;
    else if (adv_i)     ch_q <= at_last_o ? first_i : ch_q + 1'b1;
  end

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && ch_q == {CH_W{1'b1}} && !at_last_o) |=> (ch_q == '0));

  a_r3_last_to_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && at_last_o) |=> (ch_q == $past(first_i)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int DATA_W = 10,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [1:0]        rd_addr_i,
  input  logic              rmw_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              ext_trig_i,
  input  logic              tmr_trig_i,
  output logic              conv_start_o,
  output logic [CH_W:0]     conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              irq_o
);
  state_e            state_q, nxt;
  mode_e             mode_q;
  logic [1:0]        src_q;
  logic              ie_q, int_q, pause_q, bank_q, start_q;
  logic [CH_W-1:0]   first_q, last_q, ch;
  logic [DATA_W-1:0] result_q, pend_q;
  logic              ctrl_wr, range_wr, sw_start, force_stop, trig, at_last;
  logic              load, adv, go, commit, use_pend, to_hold, busy;
  logic              unused_wr;

  assign ctrl_wr    = wr_en_i && (wr_addr_i == A_CTRL);
  assign range_wr   = wr_en_i && (wr_addr_i == A_RANGE);
  assign sw_start   = ctrl_wr && wr_data_i[B_START];
  assign force_stop = ctrl_wr && !wr_data_i[B_BUSY];
  assign busy       = (state_q != ST_IDLE);
  assign unused_wr  = ^wr_data_i;

  adc_trig_sel u_trig (
    .sw_i  (sw_start),
    .ext_i (ext_trig_i),
    .tmr_i (tmr_trig_i),
    .src_i (src_q),
    .trig_o(trig)
  );

  adc_chan_ptr #(.CH_W(CH_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .adv_i    (adv),
    .first_i  (first_q),
    .last_i   (last_q),
    .ch_o     (ch),
    .at_last_o(at_last)
  );

  always_comb begin
    nxt      = state_q;
    load     = 1'b0;
    adv      = 1'b0;
    go       = 1'b0;
    commit   = 1'b0;
    use_pend = 1'b0;
    to_hold  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (trig) begin load = 1'b1; go = 1'b1; nxt = ST_CONV; end
      ST_CONV: begin
        if (trig && mode_q == MD_SINGLE_RT) begin
          load = 1'b1; go = 1'b1;
        end else if (conv_done_i) begin
          // mode bit 1 set: repeating or stepping modes hold on an unserviced flag
          if (int_q && mode_q[1]) begin to_hold = 1'b1; nxt = ST_HOLD; end
          else commit = 1'b1;
        end
      end
      ST_HOLD: if (!int_q) begin commit = 1'b1; use_pend = 1'b1; end
      ST_PARK: if (trig) begin go = 1'b1; nxt = ST_CONV; end
      default: nxt = ST_IDLE;
    endcase
    if (commit) begin
      unique case (mode_q)
        MD_CONT: begin adv = 1'b1; go = 1'b1; nxt = ST_CONV; end
        MD_STEP: begin adv = 1'b1; nxt = ST_PARK; end
        default: begin
          if (at_last) nxt = ST_IDLE;
          else begin adv = 1'b1; go = 1'b1; nxt = ST_CONV; end
        end
      endcase
    end
    if (force_stop) begin
      nxt = ST_IDLE; load = 1'b0; adv = 1'b0; go = 1'b0;
      commit = 1'b0; use_pend = 1'b0; to_hold = 1'b0;
      if (sw_start) begin load = 1'b1; go = 1'b1; nxt = ST_CONV; end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      start_q  <= 1'b0;
      result_q <= '0;
      pend_q   <= '0;
      int_q    <= 1'b0;
      pause_q  <= 1'b0;
      ie_q     <= 1'b0;
      src_q    <= '0;
      mode_q   <= MD_SINGLE_RT;
      bank_q   <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
    end else begin
      state_q <= nxt;
      start_q <= go;
      if (commit)  result_q <= use_pend ? pend_q : conv_data_i;
      if (to_hold) pend_q   <= conv_data_i;
      if (commit)                              int_q <= 1'b1;
      else if (ctrl_wr && !wr_data_i[B_INT])   int_q <= 1'b0;
      if (to_hold)                             pause_q <= 1'b1;
      else if (ctrl_wr && !wr_data_i[B_PAUSE]) pause_q <= 1'b0;
      if (ctrl_wr) begin
        ie_q   <= wr_data_i[B_IE];
        src_q  <= wr_data_i[B_SRC +: 2];
        mode_q <= mode_e'(wr_data_i[B_MODE +: 2]);
        bank_q <= wr_data_i[B_BANK];
      end
      if (range_wr) begin
        first_q <= wr_data_i[B_FIRST +: CH_W];
        last_q  <= wr_data_i[B_LAST +: CH_W];
      end
    end
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = {bank_q, ch};
  assign irq_o        = int_q & ie_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[B_BUSY]      = busy | rmw_i;
        rd_data_o[B_INT]       = int_q | rmw_i;
        rd_data_o[B_IE]        = ie_q;
        rd_data_o[B_PAUSE]     = pause_q | rmw_i;
        rd_data_o[B_SRC +: 2]  = src_q;
        rd_data_o[B_MODE +: 2] = mode_q;
        rd_data_o[B_BANK]      = bank_q;
      end
      A_RANGE: begin
        rd_data_o[B_FIRST +: CH_W] = first_q;
        rd_data_o[B_LAST +: CH_W]  = last_q;
      end
      A_RES:   rd_data_o[DATA_W-1:0] = result_q;
      default: rd_data_o = '0;
    endcase
  end

  a_r2_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy);

  a_r8_forced_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wr_data_i[B_BUSY] && !wr_data_i[B_START]) |=> (state_q == ST_IDLE));

  a_r9_flag_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> int_q);

  a_r10_held_result_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && int_q) |=> $stable(result_q));

  a_r10_no_start_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> !conv_start_o);
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic        rmw_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        ext_trig_i = 1'b0;
  logic        tmr_trig_i = 1'b0;
  logic        conv_start_o;
  logic [5:0]  conv_chan_o;
  logic        conv_done_i = 1'b0;
  logic [9:0]  conv_data_i = '0;
  logic        irq_o;

  int          n_chk = 0;
  int          n_err = 0;
  int          eng_cnt = 0;
  logic [5:0]  eng_ch = '0;
  logic [5:0]  exp_q[$];
  string       cur_req = "R1";
  logic [15:0] v;

  always #4 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rmw_i(rmw_i), .rd_data_o(rd_data_o),
    .ext_trig_i(ext_trig_i), .tmr_trig_i(tmr_trig_i), .conv_start_o(conv_start_o),
    .conv_chan_o(conv_chan_o), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] conv_val(input logic [5:0] c);
    return {4'h5, c};
  endfunction

  // monitor + engine model, all on the falling edge
  always @(negedge clk) begin
    conv_done_i = 1'b0;
    if (rst_ni && conv_start_o) begin
      if (exp_q.size() == 0) chk({cur_req, " unexpected conversion start"}, conv_chan_o, 0);
      else chk({cur_req, " scan channel"}, conv_chan_o, exp_q.pop_front());
      eng_cnt = LAT;
      eng_ch  = conv_chan_o;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        conv_done_i = 1'b1;
        conv_data_i = conv_val(eng_ch);
      end
    end
  end

  function automatic logic [15:0] cw(input logic busy, input logic intf, input logic ie,
                                     input logic pause, input logic [1:0] src, input logic start,
                                     input logic [1:0] mode, input logic bank);
    logic [15:0] w;
    w = '0;
    w[0] = busy; w[1] = intf; w[2] = ie; w[3] = pause;
    w[5:4] = src; w[6] = start; w[9:8] = mode; w[10] = bank;
    return w;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_range(input logic [4:0] f, input logic [4:0] l);
    wr(2'd1, {3'b0, l, 3'b0, f});
  endtask

  task automatic rd(input logic [1:0] a, input logic m, output logic [15:0] d);
    rd_addr_i = a; rmw_i = m;
    #1;
    d = rd_data_o;
    rd_addr_i = '0; rmw_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      if (!rd_data_o[0]) break;
    end
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_trig_i = 1'b1;
    @(negedge clk); ext_trig_i = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_trig_i = 1'b1;
    @(negedge clk); tmr_trig_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle_cycles(5);
    rst_ni = 1'b1;
    idle_cycles(2);

    // R1 reset state
    cur_req = "R1";
    rd(2'd0, 1'b0, v); chk("R1 control", v, 0);
    rd(2'd1, 1'b0, v); chk("R1 range", v, 0);
    rd(2'd2, 1'b0, v); chk("R1 result", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 start", conv_start_o, 0);
    // R11 read-modify-write view while idle
    rd(2'd0, 1'b1, v); chk("R11 rmw idle", v, 16'h000B);

    // R2 single pass ascending
    cur_req = "R2";
    set_range(5'd2, 5'd5);
    exp_q.push_back(6'd2); exp_q.push_back(6'd3); exp_q.push_back(6'd4); exp_q.push_back(6'd5);
    wr(2'd0, cw(1, 1, 0, 1, 2'b00, 1, 2'b01, 0));
    wait_idle();
    chk("R2 queue drained", exp_q.size(), 0);
    rd(2'd0, 1'b0, v); chk("R9 flag after scan", v[1], 1);
    rd(2'd2, 1'b0, v); chk("R9 result last channel", v, conv_val(6'd5));
    chk("R9 irq masked", irq_o, 0);
    wr(2'd0, cw(1, 0, 1, 1, 2'b00, 0, 2'b01, 0));
    rd(2'd0, 1'b0, v); chk("R9 flag cleared", v[1], 0);
    chk("R9 irq after clear", irq_o, 0);

    // R3 wrap and single channel
    cur_req = "R3";
    set_range(5'd30, 5'd1);
    exp_q.push_back(6'd30); exp_q.push_back(6'd31); exp_q.push_back(6'd0); exp_q.push_back(6'd1);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b01, 0));
    wait_idle();
    chk("R3 wrap drained", exp_q.size(), 0);
    rd(2'd2, 1'b0, v); chk("R3 wrap result", v, conv_val(6'd1));
    chk("R9 irq enabled", irq_o, 1);
    set_range(5'd7, 5'd7);
    exp_q.push_back(6'd7);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b01, 0));
    wait_idle();
    chk("R3 single drained", exp_q.size(), 0);
    rd(2'd2, 1'b0, v); chk("R3 single result", v, conv_val(6'd7));

    // R4 upper bank
    cur_req = "R4";
    set_range(5'd3, 5'd4);
    exp_q.push_back(6'd35); exp_q.push_back(6'd36);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b01, 1));
    wait_idle();
    chk("R4 drained", exp_q.size(), 0);
    rd(2'd2, 1'b0, v); chk("R4 result", v, conv_val(6'd36));

    // R5 trigger source gating
    cur_req = "R5";
    set_range(5'd9, 5'd9);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 0, 2'b01, 0));
    pulse_ext(); pulse_tmr(); idle_cycles(10);
    rd(2'd0, 1'b0, v); chk("R5 src00 ignores pins busy", v[0], 0);
    chk("R5 src00 nothing queued", exp_q.size(), 0);
    wr(2'd0, cw(1, 1, 1, 1, 2'b01, 0, 2'b01, 0));
    pulse_tmr(); idle_cycles(10);
    rd(2'd0, 1'b0, v); chk("R5 src01 ignores timer", v[0], 0);
    exp_q.push_back(6'd9);
    pulse_ext(); wait_idle();
    chk("R5 src01 pin start", exp_q.size(), 0);
    wr(2'd0, cw(1, 1, 1, 1, 2'b10, 0, 2'b01, 0));
    pulse_ext(); idle_cycles(10);
    rd(2'd0, 1'b0, v); chk("R5 src10 ignores pin", v[0], 0);
    exp_q.push_back(6'd9);
    pulse_tmr(); wait_idle();
    chk("R5 src10 timer start", exp_q.size(), 0);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b01, 0));
    exp_q.push_back(6'd9);
    rd(2'd0, 1'b0, v); chk("R5 start bit reads 0", v[6], 0);
    idle_cycles(1);
    wait_idle();

    // R8 writing 1 to busy while idle
    cur_req = "R8";
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 0, 2'b00, 0));
    rd(2'd0, 1'b0, v); chk("R8 busy write 1 no effect", v[0], 0);

    // R6 retrigger rules
    cur_req = "R6";
    set_range(5'd0, 5'd3);
    exp_q.push_back(6'd0);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b00, 0));
    idle_cycles(1);
    exp_q.push_back(6'd0);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b00, 0));
    exp_q.push_back(6'd1); exp_q.push_back(6'd2); exp_q.push_back(6'd3);
    wait_idle();
    chk("R6 mode00 restart", exp_q.size(), 0);
    exp_q.push_back(6'd0); exp_q.push_back(6'd1); exp_q.push_back(6'd2); exp_q.push_back(6'd3);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b01, 0));
    idle_cycles(1);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b01, 0));
    wait_idle();
    chk("R6 mode01 ignores retrigger", exp_q.size(), 0);

    // R7 / R10 repeating mode with hold
    cur_req = "R10";
    wr(2'd0, cw(1, 0, 1, 1, 2'b00, 0, 2'b10, 0));
    set_range(5'd4, 5'd5);
    exp_q.push_back(6'd4); exp_q.push_back(6'd5);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b10, 0));
    idle_cycles(30);
    rd(2'd0, 1'b0, v);
    chk("R10 pause set", v[3], 1);
    chk("R7 still busy", v[0], 1);
    rd(2'd2, 1'b0, v); chk("R10 result held", v, conv_val(6'd4));
    chk("R10 no start while held", exp_q.size(), 0);
    exp_q.push_back(6'd4);
    wr(2'd0, cw(1, 0, 1, 1, 2'b00, 0, 2'b10, 0));
    idle_cycles(1);
    rd(2'd2, 1'b0, v); chk("R10 released result", v, conv_val(6'd5));
    chk("R9 irq after release", irq_o, 1);
    idle_cycles(1);
    chk("R7 repeat restarts at first", exp_q.size(), 0);
    cur_req = "R8";
    wr(2'd0, cw(0, 1, 1, 0, 2'b00, 0, 2'b10, 0));
    rd(2'd0, 1'b0, v);
    chk("R8 forced stop", v[0], 0);
    chk("R10 pause cleared", v[3], 0);
    idle_cycles(10);
    rd(2'd2, 1'b0, v); chk("R8 late result discarded", v, conv_val(6'd5));

    // R7 step mode
    cur_req = "R7";
    wr(2'd0, cw(1, 0, 1, 1, 2'b00, 0, 2'b11, 0));
    set_range(5'd1, 5'd2);
    exp_q.push_back(6'd1);
    wr(2'd0, cw(1, 1, 1, 1, 2'b00, 1, 2'b11, 0));
    idle_cycles(12);
    rd(2'd0, 1'b0, v); chk("R7 parked busy", v[0], 1);
    rd(2'd2, 1'b0, v); chk("R7 step 1", v, conv_val(6'd1));
    exp_q.push_back(6'd2);
    wr(2'd0, cw(1, 0, 1, 1, 2'b00, 1, 2'b11, 0));
    idle_cycles(12);
    rd(2'd2, 1'b0, v); chk("R7 step 2", v, conv_val(6'd2));
    exp_q.push_back(6'd1);
    wr(2'd0, cw(1, 0, 1, 1, 2'b00, 1, 2'b11, 0));
    idle_cycles(12);
    rd(2'd2, 1'b0, v); chk("R7 step back to first", v, conv_val(6'd1));
    chk("R7 drained", exp_q.size(), 0);
    rd(2'd0, 1'b1, v); chk("R11 rmw flags", v[3:0] & 4'hB, 4'hB);
    rd(2'd0, 1'b0, v); chk("R11 plain read pause", v[3], 0);
    wr(2'd0, cw(0, 1, 1, 1, 2'b00, 0, 2'b11, 0));
    rd(2'd0, 1'b0, v); chk("R8 stop from park", v[0], 0);

    idle_cycles(5);
    chk("R2 final queue", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule